// File: doc/BRIEF.md
# PWM Generator with Duty Extremes

This block produces one pulse-width-modulated output from an up-counter and two compare values. The counter runs from zero up to the active period value, then clears to zero. The output goes high on the cycle after the period match and low on the cycle after a duty match. The output therefore stays high while the counter runs from 0 up to the duty value, and stays low from the next count until the period match.

The two extremes are handled by one rule. When the period match and the duty match fall in the same cycle, the output keeps its level. A duty value equal to the period therefore freezes whatever level the output has. From reset this gives a steady low output. When the duty value is applied while the output is high, it gives a steady high output. A duty value above the period never matches, so the output is set high at each period match and never cleared.

Period and duty writes land in pending registers. The writes take effect at the next period match, or on the next cycle while the generator is disabled, so a pulse is never cut by a rewrite. All pins are plain control and status signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_dx`

## Requirements
- R1: While `en` is high, `count_out` increases by one each cycle. In a cycle where it equals the active period, `period_match` is high and `count_out` is 0 on the next cycle.
- R2: While `en` is high, `duty_match` is high in any cycle where `count_out` equals the active duty value. If that cycle is not a period match, `pwm_out` is 0 on the next cycle.
- R3: A period match drives `pwm_out` to 1 on the next cycle, unless R4 applies.
- R4: When a period match occurs and the duty value about to become active equals the current count, `pwm_out` keeps its level on the next cycle. The duty value about to become active is the pending duty, or `duty_in` if `duty_we` is high in that cycle.
- R5: A duty value equal to the period value gives a constant output with no transitions, including in the first period after a clear. From reset the output is a steady 0. When the value is applied while the output is 1, the output is a steady 1.
- R6: A duty value greater than the period value never raises `duty_match`. After the first period match, `pwm_out` stays at 1.
- R7: A write while enabled does not change the active value until the next period match. The write is used from count 0 onward.
- R8: While `en` is low, `count_out` is 0, both match outputs are 0, and `pwm_out` holds its level. A value written in this state becomes active on the next cycle.
- R9: After reset, `count_out` is 0, `pwm_out` is 0, and the period and duty values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| period_in | input | W | New period value |
| period_we | input | 1 | Period write strobe |
| duty_in | input | W | New duty value |
| duty_we | input | 1 | Duty write strobe |
| pwm_out | output | 1 | PWM output |
| count_out | output | W | Current counter value |
| period_match | output | 1 | Counter equals active period |
| duty_match | output | 1 | Counter equals active duty |

## Verification
A counter fault appears on `count_out` and on `period_match` within one cycle. A stale or early-loaded compare value stays hidden until the count passes the old or new value. It then shows as a `duty_match` pulse or a `pwm_out` edge in the wrong cycle, within one period of the write. A wrong coincidence decision shows on `pwm_out` on the cycle after a period match, and it persists as a level that is stuck or toggling through the following periods.

// File: rtl/pwm_dx_pkg.sv
package pwm_dx_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_RISE = 2'd1,
    ACT_FALL = 2'd2
  } wave_act_e;

  function automatic wave_act_e pick_act(input logic pmatch, input logic dmatch, input logic coinc);
    if (pmatch) return coinc ? ACT_KEEP : ACT_RISE;
    if (dmatch) return ACT_FALL;
    return ACT_KEEP;
  endfunction
endpackage

// File: rtl/pwm_dx_shadow.sv
module pwm_dx_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  input  logic         load,
  output logic [W-1:0] pend,
  output logic [W-1:0] act
);
  logic [W-1:0] hold_q;

  assign pend = we ? din : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act    <= '0;
    end else begin
      hold_q <= pend;
      if (load) act <= pend;
    end
  end
endmodule

// File: rtl/pwm_dx_counter.sv
module pwm_dx_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  output logic [W-1:0] count,
  output logic         pmatch,
  output logic         dmatch
);
  localparam logic [W-1:0] ONE = W'(1);

  assign pmatch = en && (count == period);
  assign dmatch = en && (count == duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (!en || pmatch)   count <= '0;
    else                      count <= count + ONE;
  end
endmodule

// File: rtl/pwm_dx_wave.sv
module pwm_dx_wave
  import pwm_dx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pmatch,
  input  logic dmatch,
  input  logic coinc,
  output logic wave
);
  wave_act_e act;

  assign act = pick_act(pmatch, dmatch, coinc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else begin
      case (act)
        ACT_RISE: wave <= 1'b1;
        ACT_FALL: wave <= 1'b0;
        default:  wave <= wave;
      endcase
    end
  end
endmodule

// File: rtl/pwm_dx.sv
module pwm_dx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] period_in,
  input  logic         period_we,
  input  logic [W-1:0] duty_in,
  input  logic         duty_we,
  output logic         pwm_out,
  output logic [W-1:0] count_out,
  output logic         period_match,
  output logic         duty_match
);
  localparam int NREG     = 2;
  localparam int IDX_PER  = 0;
  localparam int IDX_DUTY = 1;

  logic [NREG-1:0][W-1:0] wr_val, pend_val, act_val;
  logic [NREG-1:0]        wr_en;
  logic                   load;
  logic                   coinc;
  logic [W-1:0]           duty_pend;
  logic [W-1:0]           period_cur;

  assign wr_val[IDX_PER]  = period_in;
  assign wr_val[IDX_DUTY] = duty_in;
  assign wr_en[IDX_PER]   = period_we;
  assign wr_en[IDX_DUTY]  = duty_we;

  assign load = !en || period_match;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    pwm_dx_shadow #(.W(W)) u_sh (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en[i]),
      .din  (wr_val[i]),
      .load (load),
      .pend (pend_val[i]),
      .act  (act_val[i])
    );
  end

  assign duty_pend  = pend_val[IDX_DUTY];
  assign period_cur = act_val[IDX_PER];

  pwm_dx_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .period(period_cur),
    .duty  (act_val[IDX_DUTY]),
    .count (count_out),
    .pmatch(period_match),
    .dmatch(duty_match)
  );

  assign coinc = period_match && (duty_pend == period_cur);

  pwm_dx_wave u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .pmatch(period_match),
    .dmatch(duty_match),
    .coinc (coinc),
    .wave  (pwm_out)
  );
endmodule

// File: rtl/pwm_dx_chk.sv
module pwm_dx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         pwm_out,
  input logic [W-1:0] count_out,
  input logic         period_match,
  input logic         duty_match,
  input logic [W-1:0] duty_pend
);
  // R1: a period match clears the counter
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    period_match |=> count_out == '0);

  // R1: counting between matches
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_match) |=> count_out == $past(count_out) + W'(1));

  // R2: lone duty match drives the output low
  p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_match && !period_match) |=> !pwm_out);

  // R3: period match without coincidence drives the output high
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && duty_pend != count_out) |=> pwm_out);

  // R4: coinciding matches keep the level
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && duty_pend == count_out) |=> pwm_out == $past(pwm_out));

  // R2, R3: no match, no edge
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_match && !duty_match) |=> $stable(pwm_out));

  // R8: idle state
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!period_match && !duty_match));
  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> count_out == '0);
endmodule

bind pwm_dx pwm_dx_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .pwm_out     (pwm_out),
  .count_out   (count_out),
  .period_match(period_match),
  .duty_match  (duty_match),
  .duty_pend   (duty_pend)
);

// File: tb/pwm_dx_test.sv
`timescale 1ns/1ps
module pwm_dx_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] period_in = '0;
  logic         period_we = 1'b0;
  logic [W-1:0] duty_in = '0;
  logic         duty_we = 1'b0;
  logic         pwm_out;
  logic [W-1:0] count_out;
  logic         period_match;
  logic         duty_match;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_cnt, m_pa, m_ps, m_da, m_ds;
  logic         m_out;
  logic         m_coinc;
  logic         m_prev_out;

  always #2.5 clk = ~clk;

  pwm_dx #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_in(period_in), .period_we(period_we),
    .duty_in(duty_in), .duty_we(duty_we),
    .pwm_out(pwm_out), .count_out(count_out),
    .period_match(period_match), .duty_match(duty_match)
  );

  function automatic logic f_out(input logic o, input logic pm, input logic dm, input logic co);
    if (pm) return co ? o : 1'b1;
    if (dm) return 1'b0;
    return o;
  endfunction

  function automatic logic [W-1:0] f_cnt(input logic [W-1:0] c, input logic e, input logic pm);
    if (!e || pm) return '0;
    return c + W'(1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic pm, dm;
    logic [W-1:0] pn, dn;
    pm = en && (m_cnt == m_pa);
    dm = en && (m_cnt == m_da);
    pn = period_we ? period_in : m_ps;
    dn = duty_we ? duty_in : m_ds;
    m_coinc    = pm && (dn == m_pa);
    m_prev_out = m_out;
    m_out = f_out(m_out, pm, dm, m_coinc);
    m_cnt = f_cnt(m_cnt, en, pm);
    m_ps = pn;
    m_ds = dn;
    if (!en || pm) begin
      m_pa = pn;
      m_da = dn;
    end
  endtask

  task automatic compare();
    chk(count_out == m_cnt, "R1 count", count_out, m_cnt);
    chk(period_match == (en && m_cnt == m_pa), "R1 period_match", period_match, en && m_cnt == m_pa);
    chk(duty_match == (en && m_cnt == m_da), "R2 duty_match", duty_match, en && m_cnt == m_da);
    chk(pwm_out == m_out, "R3 pwm_out", pwm_out, m_out);
    if (m_coinc) chk(pwm_out == m_prev_out, "R4 hold on coincidence", pwm_out, m_prev_out);
  endtask

  // called just after a falling edge
  task automatic cyc(input logic e, input logic pw, input int pv, input logic dw, input int dv);
    en = e; period_we = pw; period_in = W'(pv); duty_we = dw; duty_in = W'(dv);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    period_we = 1'b0; duty_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    void'($urandom(32'h1357));
    m_cnt = '0; m_pa = '0; m_ps = '0; m_da = '0; m_ds = '0; m_out = 1'b0;
    m_coinc = 1'b0; m_prev_out = 1'b0;
    repeat (3) @(negedge clk);
    chk(count_out == 0, "R9 reset count", count_out, 0);
    chk(pwm_out == 0, "R9 reset output", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R5: duty == period from reset gives steady low
    cyc(1'b0, 1'b1, 7, 1'b1, 7);
    cyc(1'b0, 1'b0, 0, 1'b0, 0);
    for (int i = 0; i < 24; i++) begin
      cyc(1'b1, 1'b0, 0, 1'b0, 0);
      chk(pwm_out == 0, "R5 zero duty steady", pwm_out, 0);
    end

    // R6: duty above period never matches, output high after first clear
    cyc(1'b1, 1'b0, 0, 1'b1, 9);
    run(10);
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, 0, 1'b0, 0);
      chk(pwm_out == 1, "R6 no fall when duty above period", pwm_out, 1);
      chk(duty_match == 0, "R6 no duty match", duty_match, 0);
    end

    // R5: duty == period applied while high gives steady high
    cyc(1'b1, 1'b0, 0, 1'b1, 7);
    for (int i = 0; i < 24; i++) begin
      cyc(1'b1, 1'b0, 0, 1'b0, 0);
      chk(pwm_out == 1, "R5 full duty steady", pwm_out, 1);
    end

    // R7: new duty waits for the period match
    while (count_out != 2) cyc(1'b1, 1'b0, 0, 1'b0, 0);
    cyc(1'b1, 1'b0, 0, 1'b1, 3);
    while (count_out != 0) begin
      chk(pwm_out == 1, "R7 old duty kept until period match", pwm_out, 1);
      cyc(1'b1, 1'b0, 0, 1'b0, 0);
    end
    while (count_out != 4) cyc(1'b1, 1'b0, 0, 1'b0, 0);
    chk(pwm_out == 0, "R2 low after duty match", pwm_out, 0);
    while (count_out != 0) cyc(1'b1, 1'b0, 0, 1'b0, 0);
    chk(pwm_out == 1, "R3 high after period match", pwm_out, 1);

    // R8: disabled state
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b0, 0, 1'b0, 0);
      chk(count_out == 0, "R8 idle count", count_out, 0);
      chk(!period_match && !duty_match, "R8 idle matches", {period_match, duty_match}, 0);
      chk(pwm_out == 1, "R8 idle output held", pwm_out, 1);
    end

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic e, pw, dw;
      int pv, dv;
      e  = ($urandom_range(0, 19) != 0);
      pw = ($urandom_range(0, 29) == 0);
      dw = ($urandom_range(0, 9) == 0);
      pv = $urandom_range(0, 12);
      dv = $urandom_range(0, 15);
      cyc(e, pw, pv, dw, dv);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule